// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns stereo PCM sample pairs into a single serial data line for an audio codec. The bit clock and the frame (word-select) clock come from outside, from a clock generator or from the codec itself. Both are oversampled in the block's system clock domain, and data is launched on the chosen bit-clock edge. One pair (left, right) is accepted through a valid/ready handshake and held until the next frame begins. At that point the pair is moved into the serializer.

Three framings share one datapath:
- one-bit-delayed (I2S), where the MSB follows the frame-clock change by one bit clock;
- left-justified, where the MSB lines up with the frame-clock change;
- right-justified, where the LSB ends the channel slot.

The word length (16, 24 or 32 bits) is set independently of the slot length (16, 32 or 64 bit clocks per channel). Slot positions that carry no word bit are driven low. If a frame starts while the transmitter is enabled and no pair is waiting, that frame is all zeros and an underflow strobe is raised. The enable takes effect only at frame boundaries.

Top module: `pcm_serial_tx`

## Requirements
- R1: After reset, `sdata` is 0, `s_ready` is 1 and `underflow` is 0.
- R2: A pair is taken when `s_valid` and `s_ready` are both high on a clock edge. `s_ready` then stays low until a frame start consumes the pair.
- R3: A launch edge on which the frame clock indicates the right channel is followed by a launch edge on which it indicates the left channel. That second launch edge is frame position 0. With `lrck_inv`=0 the frame clock is low for the left channel; with `lrck_inv`=1 it is high for the left channel.
- R4: With `bclk_edge`=0, `sdata` changes only after falling bit-clock edges. With `bclk_edge`=1, it changes only after rising edges. Data is stable at the opposite edge.
- R5: Words are sent MSB first, taken from the low bits of each sample input. `wlen_code` 0 selects 16 bits, 1 selects 24 bits, and 2 or 3 select 32 bits.
- R6: With `fmt_i2s`=0 and `fmt_rjust`=0, the left MSB is at frame position 0 and the right MSB is at position S, where S is the slot length.
- R7: With `fmt_i2s`=1, every bit comes one position later than in R6. Position 0 of a frame carries the last bit of the previous frame's right slot.
- R8: With `fmt_rjust`=1 (and `fmt_i2s`=0), each word's LSB is at the last position of its slot, and earlier positions are zero.
- R9: `slot_code` 0, 1, 2/3 selects S = 16, 32, 64. Slot positions outside the word are zero. Word bits that do not fit in the slot are dropped.
- R10: A frame start with `tx_en`=1 and no pair held produces an all-zero frame and a one-cycle `underflow` pulse.
- R11: `tx_en` is sampled only at frame start. A running frame completes after `tx_en` falls. A frame started while disabled is all zeros, raises no underflow and leaves a held pair in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable, sampled at frame start |
| fmt_i2s | input | 1 | 1: MSB delayed one bit clock after frame-clock change |
| fmt_rjust | input | 1 | 1: LSB aligned to the end of the slot |
| wlen_code | input | 2 | Word length code (16/24/32) |
| slot_code | input | 2 | Slot length code (16/32/64 bit clocks) |
| bclk_edge | input | 1 | 0: launch on falling edge, 1: launch on rising edge |
| lrck_inv | input | 1 | 0: frame clock low for left, 1: high for left |
| bclk | input | 1 | External bit clock |
| lrck | input | 1 | External frame clock |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Sample pair can be accepted |
| s_left | input | SAMPLE_W | Left sample, LSB-aligned |
| s_right | input | SAMPLE_W | Right sample, LSB-aligned |
| sdata | output | 1 | Serial data line |
| underflow | output | 1 | One-cycle pulse at a starved frame start |

## Verification
The hardest case to reach is the boundary between frames in delayed framing. The first launch of a frame must still carry the previous frame's right-channel LSB, while the new pair is being loaded on that same edge. The bench reaches this case by running frames back to back with different pairs. It also rebuilds each frame's bit layout from the requirements and carries the previous layout forward. A second hard case is the enable falling in the middle of a frame while another pair is waiting. The bench drops `tx_en` partway through a frame, queues the next pair, and checks both the zero frame that follows and the fact that `s_ready` stays low.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  // word length in bits from its code
  function automatic int wlen_bits(logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 24;
      default: return 32;
    endcase
  endfunction

  // bit clocks per channel slot from its code
  function automatic int slot_bits(logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 32;
      default: return 64;
    endcase
  endfunction

  // bit of word w that sits at slot position b (0 = first in slot)
  function automatic logic slot_bit(logic [63:0] w, int b, int wl, int sl, logic rj);
    int k;
    k = rj ? b - (sl - wl) : b;
    if (k < 0 || k >= wl) return 1'b0;
    return w[wl - 1 - k];
  endfunction

endpackage

// File: rtl/pcm_tx_edges.sv
module pcm_tx_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrck,
  input  logic bclk_edge,
  input  logic lrck_inv,
  output logic launch,
  output logic chan_right,
  output logic frame_start
);
  logic b_q, b_q2, l_q, prev_right;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q        <= 1'b0;
      b_q2       <= 1'b0;
      l_q        <= 1'b0;
      prev_right <= 1'b1;
    end else begin
      b_q  <= bclk;
      b_q2 <= b_q;
      l_q  <= lrck;
      if (launch) prev_right <= chan_right;
    end
  end

  assign launch      = (b_q != b_q2) && (b_q == bclk_edge);
  assign chan_right  = l_q ^ lrck_inv;
  assign frame_start = launch && !chan_right && prev_right;

  // R3: two launches never come on adjacent cycles
  p_launch_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
endmodule

// File: rtl/pcm_tx_hold.sv
module pcm_tx_hold #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                take,
  output logic                pend_v,
  output logic [SAMPLE_W-1:0] pend_l,
  output logic [SAMPLE_W-1:0] pend_r
);
  logic accept;
  assign s_ready = !pend_v;
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_l <= '0;
      pend_r <= '0;
    end else if (accept) begin
      pend_v <= 1'b1;
      pend_l <= s_left;
      pend_r <= s_right;
    end else if (take) begin
      pend_v <= 1'b0;
    end
  end

  // R2: an accepted pair closes the handshake
  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !s_ready);
  // R11: a held pair stays until the serializer takes it
  p_held_until_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !take) |=> !s_ready);
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int SAMPLE_W = 32,
  parameter int FCW      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                frame_start,
  input  logic                tx_en,
  input  logic                fmt_i2s,
  input  logic                fmt_rjust,
  input  logic [1:0]          wlen_code,
  input  logic [1:0]          slot_code,
  input  logic                pend_v,
  input  logic [SAMPLE_W-1:0] pend_l,
  input  logic [SAMPLE_W-1:0] pend_r,
  output logic                take,
  output logic                sdata,
  output logic                underflow
);
  import pcm_tx_pkg::*;

  logic [FCW-1:0]      fcnt, pos;
  logic [SAMPLE_W-1:0] cur_l, cur_r, new_l, new_r, src_l, src_r;
  int                  sl, wl, fl, d, b;
  logic                in_right, nxt_bit;

  always_comb begin
    sl    = slot_bits(slot_code);
    wl    = wlen_bits(wlen_code);
    fl    = 2 * sl;
    pos   = frame_start ? '0 : fcnt + FCW'(1);
    take  = frame_start && tx_en && pend_v;
    new_l = take ? pend_l : '0;
    new_r = take ? pend_r : '0;
    // delayed framing: frame position 0 still belongs to the old pair
    src_l = (frame_start && !fmt_i2s) ? new_l : cur_l;
    src_r = (frame_start && !fmt_i2s) ? new_r : cur_r;
    d        = (int'(pos) + fl - (fmt_i2s ? 1 : 0)) % fl;
    in_right = (d >= sl);
    b        = in_right ? d - sl : d;
    nxt_bit  = slot_bit(in_right ? 64'(src_r) : 64'(src_l), b, wl, sl, fmt_rjust);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt      <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
      sdata     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= frame_start && tx_en && !pend_v;
      if (launch) begin
        fcnt  <= pos;
        sdata <= nxt_bit;
      end
      if (frame_start) begin
        cur_l <= new_l;
        cur_r <= new_r;
      end
    end
  end

  // R4: the line moves only on the selected launch edge
  p_sdata_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sdata));
  // R10: underflow follows a frame start
  p_uflow_at_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(frame_start));
  // R10: underflow is a single-cycle strobe
  p_uflow_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int SAMPLE_W = 32,
  parameter int MAX_SLOT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic                fmt_i2s,
  input  logic                fmt_rjust,
  input  logic [1:0]          wlen_code,
  input  logic [1:0]          slot_code,
  input  logic                bclk_edge,
  input  logic                lrck_inv,
  input  logic                bclk,
  input  logic                lrck,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                sdata,
  output logic                underflow
);
  localparam int FCW = $clog2(2 * MAX_SLOT) + 1;

  logic                launch, chan_right, frame_start, take, pend_v;
  logic [SAMPLE_W-1:0] pend_l, pend_r;

  pcm_tx_edges u_edges (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck),
    .bclk_edge(bclk_edge), .lrck_inv(lrck_inv),
    .launch(launch), .chan_right(chan_right), .frame_start(frame_start)
  );

  pcm_tx_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .take(take),
    .pend_v(pend_v), .pend_l(pend_l), .pend_r(pend_r)
  );

  pcm_tx_ser #(.SAMPLE_W(SAMPLE_W), .FCW(FCW)) u_ser (
    .clk(clk), .rst_n(rst_n), .launch(launch), .frame_start(frame_start),
    .tx_en(tx_en), .fmt_i2s(fmt_i2s), .fmt_rjust(fmt_rjust),
    .wlen_code(wlen_code), .slot_code(slot_code),
    .pend_v(pend_v), .pend_l(pend_l), .pend_r(pend_r),
    .take(take), .sdata(sdata), .underflow(underflow)
  );
endmodule

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;
  logic        clk = 0, rst_n = 0;
  logic        tx_en = 0, fmt_i2s = 0, fmt_rjust = 0, bclk_edge = 0, lrck_inv = 0;
  logic [1:0]  wlen_code = 0, slot_code = 0;
  logic        bclk = 1, lrck = 1, s_valid = 0;
  logic [31:0] s_left = 0, s_right = 0;
  logic        s_ready, sdata, underflow;

  pcm_serial_tx u0 (.*);

  always #10 clk = ~clk;

  typedef struct { logic b; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0, uf_cnt = 0, uf_exp = 0;
  event cap_ev;
  logic [127:0] prev_lay = '0;
  logic [31:0]  bl = 0, br = 0;
  bit           bpend = 0;

  always @(posedge clk) if (rst_n && underflow) uf_cnt++;

  // monitor: pops one expected bit per capture edge
  initial forever begin
    @(cap_ev);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (sdata !== e.b) begin
        n_bad++;
        $display("FAIL %s sdata act=%b exp=%b", e.tag, sdata, e.b);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int wl_of(logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 24 : 32;
  endfunction
  function automatic int sl_of(logic [1:0] c);
    return 16 << ((c > 2) ? 2 : c);
  endfunction

  // frame image per R5/R6/R8/R9, undelayed
  function automatic logic [127:0] layout(logic [31:0] l, logic [31:0] r);
    logic [127:0] lay = '0;
    int wl = wl_of(wlen_code), sl = sl_of(slot_code);
    for (int c = 0; c < 2; c++) begin
      logic [31:0] w = c ? r : l;
      int st = fmt_rjust ? sl - wl : 0;
      for (int j = 0; j < wl; j++) begin
        int idx = st + j;
        if (idx >= 0 && idx < sl) lay[c * sl + idx] = w[wl - 1 - j];
      end
    end
    return lay;
  endfunction

  // one bit period; driver pushes the expected bit before the capture edge
  task automatic bit_period(bit right, logic e, string tag);
    @(negedge clk);
    bclk = bclk_edge;
    lrck = right ^ lrck_inv;
    repeat (4) @(negedge clk);
    q.push_back('{e, tag});
    ->cap_ev;
    bclk = ~bclk_edge;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; s_valid = 0; tx_en = 0;
    bclk = ~bclk_edge; lrck = 1'b1 ^ lrck_inv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    prev_lay = '0; bpend = 0;
    bit_period(1, 1'b0, "R3 idle");
    bit_period(1, 1'b0, "R3 idle");
  endtask

  task automatic send(logic [31:0] l, logic [31:0] r);
    @(negedge clk);
    chk(s_ready === 1'b1, "R2 ready before send", s_ready, 1);
    s_valid = 1; s_left = l; s_right = r;
    @(negedge clk);
    s_valid = 0;
    bl = l; br = r; bpend = 1;
    chk(s_ready === 1'b0, "R2 ready after accept", s_ready, 0);
  endtask

  task automatic run_frame(string tag, int drop_at);
    int sl = sl_of(slot_code), fl = 2 * sl;
    logic [127:0] lay;
    bit use_pair = tx_en && bpend;
    if (tx_en && !bpend) uf_exp++;
    lay = use_pair ? layout(bl, br) : '0;
    if (use_pair) bpend = 0;
    for (int p = 0; p < fl; p++) begin
      logic e;
      if (fmt_i2s) e = (p == 0) ? prev_lay[fl - 1] : lay[p - 1];
      else         e = lay[p];
      if (p == drop_at) tx_en = 0;
      bit_period(p >= sl, e, tag);
      if (p == 0) chk(uf_cnt == uf_exp, "R10 underflow count", uf_cnt, uf_exp);
    end
    prev_lay = lay;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(sdata === 1'b0, "R1 sdata", sdata, 0);
    chk(s_ready === 1'b1, "R1 s_ready", s_ready, 1);
    chk(underflow === 1'b0, "R1 underflow", underflow, 0);

    // R6/R5 left-justified 16 in 16
    tx_en = 1;
    send(32'h0000_A5C3, 32'h0000_1E0F); run_frame("R6 lj16", -1);
    send(32'h0000_8001, 32'h0000_7FFE); run_frame("R5 msb first", -1);

    // R7 delayed framing, 24 in 32
    fmt_i2s = 1; wlen_code = 1; slot_code = 1; do_reset(); tx_en = 1;
    send(32'h00C3_5A81, 32'h0012_3457); run_frame("R7 i2s", -1);
    send(32'h0080_0001, 32'h00FF_00F1); run_frame("R7 i2s tail", -1);
    send(32'h0, 32'h0); run_frame("R7 tail to zero", -1);

    // R4 launch on rising edge
    bclk_edge = 1; do_reset(); tx_en = 1;
    send(32'h00AB_CDEF, 32'h0055_AA33); run_frame("R4 rising", -1);
    send(32'h0001_0203, 32'h00F0_0F0F); run_frame("R4 rising", -1);

    // R3 inverted frame clock
    bclk_edge = 0; lrck_inv = 1; fmt_i2s = 0; do_reset(); tx_en = 1;
    send(32'h00F0_0001, 32'h000F_FFFE); run_frame("R3 lrck_inv", -1);
    send(32'h0033_3333, 32'h00CC_CCCC); run_frame("R3 lrck_inv", -1);

    // R8 right-justified 16 and 24 in 32
    lrck_inv = 0; fmt_rjust = 1; wlen_code = 0; slot_code = 1; do_reset(); tx_en = 1;
    send(32'h0000_C001, 32'h0000_8003); run_frame("R8 rj16", -1);
    wlen_code = 1;
    send(32'h0080_0001, 32'h00A5_5A5B); run_frame("R8 rj24", -1);

    // R9 32 in 64, code 3, and 32 in 16 truncated
    fmt_rjust = 0; wlen_code = 2; slot_code = 2; do_reset(); tx_en = 1;
    send(32'hDEAD_BEEF, 32'h8000_0001); run_frame("R9 lj32 slot64", -1);
    wlen_code = 3; slot_code = 3;
    send(32'h1234_5678, 32'hF0E1_D2C3); run_frame("R5 code3 slot64", -1);
    wlen_code = 2; slot_code = 0; do_reset(); tx_en = 1;
    send(32'hABCD_1234, 32'h5678_9ABC); run_frame("R9 truncate", -1);

    // R10 underflow then recovery
    wlen_code = 0; slot_code = 1; do_reset(); tx_en = 1; uf_exp = uf_cnt;
    run_frame("R10 zero frame", -1);
    send(32'h0000_F00F, 32'h0000_0FF0); run_frame("R10 recovery", -1);
    chk(uf_cnt == uf_exp, "R10 no extra pulse", uf_cnt, uf_exp);

    // R11 enable drops mid-frame; next pair waits
    send(32'h0000_9999, 32'h0000_6666); run_frame("R11 completes", 10);
    send(32'h0000_1357, 32'h0000_2468);
    run_frame("R11 disabled zeros", -1);
    chk(s_ready === 1'b0, "R11 pair kept", s_ready, 0);
    chk(uf_cnt == uf_exp, "R11 no underflow", uf_cnt, uf_exp);
    tx_en = 1;
    run_frame("R11 resumes", -1);
    chk(s_ready === 1'b1, "R11 pair taken", s_ready, 1);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule